// File: doc/BRIEF.md
# Interrupt Steering and Aggregation Controller

This block gathers a wide vector of level-sensitive interrupt sources and exposes them to software in 32-bit groups. Each source has an enable (mask) bit and a software force bit. The qualified status of each source is the synchronized raw level or its force bit, and the result is gated by its enable. Every 64 consecutive sources feed one registered aggregated output line. Each output line can be silenced by its own disable bit. A single "anything pending" bit reports whether any qualified source is active, whatever the disables hold.

Software reaches the block through a plain register port with address, write strobe, write data and combinational read data. The mask, force and status banks are indexed in reverse group order: register index 0 holds the highest group. Raw sources pass through a synchronizer first, because they may come from other clock domains.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, all mask, force and disable bits are 0, every aggregated output is low, and the pending bit reads 0.
- R2: Address bits [7:5] select the bank: 0 mask, 1 force, 2 status (read-only), 3 control. Bits [4:0] are the register index. Source s sits at bit s mod 32 of index (G-1) - floor(s/32), where G = NUM_SRC/32. The mask, force and status banks all use this placement.
- R3: The status bit of a source is (synchronized raw level OR force bit) AND mask bit. A source whose mask bit is 0 never shows in status or on an output.
- R4: The force and mask banks are separate storage. Writing one leaves the other unchanged, and a forced source with its mask set is asserted even while its raw input is low.
- R5: Output m is high one clock after any status bit among sources 64m..64m+63 is high, provided its disable bit is 0.
- R6: Control index 1 bit 0 reads 1 whenever any status bit is set, even when the matching outputs are disabled.
- R7: A change on a raw source appears in the status bank after the second rising clock edge and on the output after the third.
- R8: Reads of unimplemented addresses return 0. Writes to unimplemented addresses, to the status bank, or to the pending bit change no state.
- R9: Control index 0 holds one disable bit per output, where 1 silences output m. A disable written in a cycle takes effect on the output one edge later than the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Raw level interrupt sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address (bank, index) |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read data |
| mst_irq | output | NUM_SRC/64 | Registered aggregated outputs |

## Verification
Two things can happen in the same cycle: a write to the disable register and the output register sampling an active master. The bench raises the strobe for a disable write while master 0 is active. It expects the output still high after that edge, because it samples the old disable, and low one edge later. A second overlap puts a raw source edge in the synchronizer while status is read with the address held. The bench judges it by reading 0 after one edge, 1 after two, and seeing the output rise only after the third.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int unsigned GRP_W = 32;
   localparam int unsigned IDX_W = 5;
   localparam int unsigned BANK_W = 3;

   typedef enum logic [BANK_W-1:0] {
      BANK_MASK  = 3'd0,
      BANK_FORCE = 3'd1,
      BANK_STAT  = 3'd2,
      BANK_CTRL  = 3'd3
   } bank_e;

   localparam logic [IDX_W-1:0] CTRL_DISABLE = 5'd0;
   localparam logic [IDX_W-1:0] CTRL_PENDING = 5'd1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_SRC = 512,
   parameter int unsigned NUM_MST = 8,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [GRP_W-1:0]   wr_data,
   input  logic [NUM_SRC-1:0] status,
   input  logic               any_stat,
   output logic [NUM_SRC-1:0] mask_vec,
   output logic [NUM_SRC-1:0] force_vec,
   output logic [NUM_MST-1:0] dis,
   output logic [GRP_W-1:0]   rd_data
);
   localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;
   localparam int unsigned GIDX_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

   logic [GRP_W-1:0]  mask_q  [NUM_GRP];
   logic [GRP_W-1:0]  force_q [NUM_GRP];
   logic [GRP_W-1:0]  stat_a  [NUM_GRP];
   logic [NUM_MST-1:0] dis_q;

   logic [BANK_W-1:0] bank;
   logic [IDX_W-1:0]  idx;
   logic [GIDX_W-1:0] gidx;
   logic              idx_ok;

   assign bank   = addr[IDX_W +: BANK_W];
   assign idx    = addr[IDX_W-1:0];
   assign gidx   = idx[GIDX_W-1:0];
   assign idx_ok = (int'(idx) < int'(NUM_GRP));

   // register index i holds group NUM_GRP-1-i
   generate
      for (genvar i = 0; i < int'(NUM_GRP); i++) begin : g_map
         localparam int unsigned GRP = NUM_GRP - 1 - i;
         assign mask_vec [GRP*GRP_W +: GRP_W] = mask_q[i];
         assign force_vec[GRP*GRP_W +: GRP_W] = force_q[i];
         assign stat_a[i] = status[GRP*GRP_W +: GRP_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_GRP); i++) begin
            mask_q[i]  <= '0;
            force_q[i] <= '0;
         end
         dis_q <= '0;
      end else if (wr_en) begin
         case (bank)
            BANK_MASK:  if (idx_ok) mask_q[gidx]  <= wr_data;
            BANK_FORCE: if (idx_ok) force_q[gidx] <= wr_data;
            BANK_CTRL:  if (idx == CTRL_DISABLE) dis_q <= wr_data[NUM_MST-1:0];
            default: ;
         endcase
      end
   end

   assign dis = dis_q;

   always_comb begin
      rd_data = '0;
      case (bank)
         BANK_MASK:  if (idx_ok) rd_data = mask_q[gidx];
         BANK_FORCE: if (idx_ok) rd_data = force_q[gidx];
         BANK_STAT:  if (idx_ok) rd_data = stat_a[gidx];
         BANK_CTRL: begin
            if (idx == CTRL_DISABLE)      rd_data[NUM_MST-1:0] = dis_q;
            else if (idx == CTRL_PENDING) rd_data[0] = any_stat;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/irq_master_agg.sv
module irq_master_agg #(
   parameter int unsigned NUM_SRC     = 512,
   parameter int unsigned SRC_PER_MST = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             status,
   input  logic [NUM_SRC/SRC_PER_MST-1:0] dis,
   output logic [NUM_SRC/SRC_PER_MST-1:0] mst_irq,
   output logic                           any_stat
);
   localparam int unsigned NUM_MST = NUM_SRC / SRC_PER_MST;

   logic [NUM_MST-1:0] hit;

   generate
      for (genvar m = 0; m < int'(NUM_MST); m++) begin : g_mst
         assign hit[m] = (|status[m*SRC_PER_MST +: SRC_PER_MST]) & ~dis[m];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mst_irq <= '0;
      else        mst_irq <= hit;
   end

   assign any_stat = |status;
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 512,
   parameter int unsigned SRC_PER_MST = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             src_irq,
   input  logic                           wr_en,
   input  logic [7:0]                     addr,
   input  logic [31:0]                    wr_data,
   output logic [31:0]                    rd_data,
   output logic [NUM_SRC/SRC_PER_MST-1:0] mst_irq
);
   localparam int unsigned NUM_MST = NUM_SRC / SRC_PER_MST;
   localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;
   localparam int unsigned ADDR_W  = BANK_W + IDX_W;

   generate
      if (SRC_PER_MST % GRP_W != 0) begin : g_bad_mst
         $error("SRC_PER_MST must be a multiple of the group width");
      end
      if (NUM_SRC % SRC_PER_MST != 0) begin : g_bad_src
         $error("NUM_SRC must be a multiple of SRC_PER_MST");
      end
      if (NUM_GRP > (1 << IDX_W) || NUM_GRP < 2) begin : g_bad_grp
         $error("group count must fit the index field");
      end
      if (NUM_MST > GRP_W) begin : g_bad_cnt
         $error("too many masters for one disable register");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_s;
   logic [NUM_SRC-1:0] mask_w;
   logic [NUM_SRC-1:0] force_w;
   logic [NUM_SRC-1:0] status_w;
   logic [NUM_MST-1:0] dis_w;
   logic               any_stat_w;

   irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_irq), .q(src_s)
   );

   assign status_w = (src_s | force_w) & mask_w;

   irq_regbank #(.NUM_SRC(NUM_SRC), .NUM_MST(NUM_MST), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .status(status_w), .any_stat(any_stat_w), .mask_vec(mask_w),
      .force_vec(force_w), .dis(dis_w), .rd_data(rd_data)
   );

   irq_master_agg #(.NUM_SRC(NUM_SRC), .SRC_PER_MST(SRC_PER_MST)) u_agg (
      .clk(clk), .rst_n(rst_n), .status(status_w), .dis(dis_w),
      .mst_irq(mst_irq), .any_stat(any_stat_w)
   );
endmodule

// File: rtl/irq_steer_agg_chk.sv
module irq_steer_agg_chk #(
   parameter int unsigned NUM_SRC     = 512,
   parameter int unsigned SRC_PER_MST = 64
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_SRC/SRC_PER_MST-1:0] mst_irq,
   input logic [NUM_SRC/SRC_PER_MST-1:0] dis,
   input logic [NUM_SRC-1:0]             status,
   input logic [NUM_SRC-1:0]             mask_vec,
   input logic                           any_stat
);
   localparam int unsigned NUM_MST = NUM_SRC / SRC_PER_MST;

   generate
      for (genvar m = 0; m < int'(NUM_MST); m++) begin : g_m
         // R9: a set disable bit silences the output at the next edge
         assert_dis_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            dis[m] |=> !mst_irq[m]);
         // R5: a high output needs an active source of its own range one cycle earlier
         assert_out_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
            mst_irq[m] |-> $past(|status[m*SRC_PER_MST +: SRC_PER_MST]));
      end
   endgenerate

   // R3: with every enable cleared nothing reaches status
   assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_vec == '0) |-> (status == '0));

   // R6: any active output implies the pending bit was set the cycle before
   assert_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|mst_irq) |-> $past(any_stat));
endmodule

bind irq_steer_agg irq_steer_agg_chk #(.NUM_SRC(NUM_SRC), .SRC_PER_MST(SRC_PER_MST)) u_chk (
   .clk(clk), .rst_n(rst_n), .mst_irq(mst_irq), .dis(dis_w),
   .status(status_w), .mask_vec(mask_w), .any_stat(any_stat_w)
);

// File: tb/irq_steer_agg_test.sv
module irq_steer_agg_test;
   localparam int NSRC = 512;
   localparam int NGRP = NSRC / 32;
   localparam int NMST = NSRC / 64;

   // vector: [12:4] source, [3] raw, [2] mask, [1] force, [0] disable
   localparam logic [12:0] VEC [10] = '{
      {9'd0,   4'b1100}, {9'd5,   4'b1000}, {9'd63,  4'b0110},
      {9'd64,  4'b1101}, {9'd511, 4'b1100}, {9'd300, 4'b0010},
      {9'd480, 4'b1110}, {9'd128, 4'b0100}, {9'd33,  4'b0111},
      {9'd447, 4'b1100}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_irq = '0;
   logic            wr_en = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic [NMST-1:0] mst_irq;
   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   irq_steer_agg uut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .mst_irq(mst_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] b, input logic [4:0] i, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = {b, i}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] b, input logic [4:0] i, output logic [31:0] d);
      @(negedge clk);
      addr = {b, i};
      #1 d = rd_data;
   endtask

   task automatic clear_all();
      src_irq = '0;
      for (int i = 0; i < NGRP; i++) begin
         wr(3'd0, 5'(i), 32'h0);
         wr(3'd1, 5'(i), 32'h0);
      end
      wr(3'd3, 5'd0, 32'h0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 outputs", 32'(mst_irq), 32'h0);
      rd(3'd0, 5'd0, d);  check("R1 mask", d, 32'h0);
      rd(3'd1, 5'd15, d); check("R1 force", d, 32'h0);
      rd(3'd3, 5'd0, d);  check("R1 disable", d, 32'h0);
      rd(3'd3, 5'd1, d);  check("R1 pending", d, 32'h0);

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < 10; v++) begin
         int s, g, b, m, idx;
         logic r, mk, f, ds, st;
         s = int'(VEC[v][12:4]);
         r = VEC[v][3]; mk = VEC[v][2]; f = VEC[v][1]; ds = VEC[v][0];
         g = s / 32; b = s % 32; m = s / 64; idx = NGRP - 1 - g;
         st = (r | f) & mk;
         clear_all();
         src_irq[s] = r;
         if (mk) wr(3'd0, 5'(idx), 32'h1 << b);
         if (f)  wr(3'd1, 5'(idx), 32'h1 << b);
         if (ds) wr(3'd3, 5'd0, 32'h1 << m);
         repeat (4) @(negedge clk);
         check("R5 table output", 32'(mst_irq), 32'(st & ~ds) << m);
         rd(3'd2, 5'(idx), d); check("R2 R3 table status", d, 32'(st) << b);
         rd(3'd3, 5'd1, d);    check("R6 table pending", d, 32'(st));
         rd(3'd1, 5'(idx), d); check("R4 table force kept", d, 32'(f) << b);
      end

      // R7 synchronizer latency, with read address held
      clear_all();
      wr(3'd0, 5'd15, 32'h1);
      @(negedge clk);
      addr = {3'd2, 5'd15};
      src_irq[0] = 1'b1;
      @(negedge clk);
      check("R7 status after one edge", rd_data, 32'h0);
      @(negedge clk);
      check("R7 status after two edges", rd_data, 32'h1);
      check("R7 output after two edges", 32'(mst_irq), 32'h0);
      @(negedge clk);
      check("R7 output after three edges", 32'(mst_irq), 32'h1);

      // R9 disable write in the same cycle the output samples
      @(negedge clk);
      wr_en = 1'b1; addr = {3'd3, 5'd0}; wr_data = 32'h1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R9 output at disable edge", 32'(mst_irq), 32'h1);
      @(negedge clk);
      check("R9 output after disable", 32'(mst_irq), 32'h0);
      rd(3'd3, 5'd1, d); check("R6 pending while disabled", d, 32'h1);

      // R4 clearing mask keeps force, and force drives with raw low
      src_irq[0] = 1'b0;
      wr(3'd3, 5'd0, 32'h0);
      wr(3'd1, 5'd15, 32'h1);
      wr(3'd0, 5'd15, 32'h0);
      rd(3'd1, 5'd15, d); check("R4 force after mask clear", d, 32'h1);
      rd(3'd2, 5'd15, d); check("R3 masked force hidden", d, 32'h0);
      wr(3'd0, 5'd15, 32'h1);
      repeat (2) @(negedge clk);
      check("R4 forced output", 32'(mst_irq), 32'h1);

      // R8 unimplemented and read-only locations
      wr(3'd5, 5'd3, 32'hFFFF_FFFF);
      rd(3'd5, 5'd3, d);  check("R8 unimpl bank read", d, 32'h0);
      wr(3'd0, 5'd20, 32'hFFFF_FFFF);
      rd(3'd0, 5'd20, d); check("R8 unimpl index read", d, 32'h0);
      rd(3'd0, 5'd4, d);  check("R8 mask index 4 untouched", d, 32'h0);
      wr(3'd3, 5'd1, 32'h0);
      rd(3'd3, 5'd1, d);  check("R8 pending not writable", d, 32'h1);
      rd(3'd3, 5'd0, d);  check("R8 disable untouched", d, 32'h0);
      wr(3'd2, 5'd15, 32'h0);
      rd(3'd2, 5'd15, d); check("R8 status not writable", d, 32'h1);
      check("R8 output unchanged", 32'(mst_irq), 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule